// File: doc/BRIEF.md
# Push-Button Triggered SPI Byte Master

This block runs one full-duplex byte exchange over SPI each time an operator presses a button. It lives in a fast system clock domain. A base enable tick is derived from that clock, and the serial clock runs at a quarter of the tick rate. With the defaults, a 50 MHz system clock gives a 400 kHz tick and a 100 kHz serial clock. The raw button passes through a flop synchronizer and then a stability-count debouncer. The rising edge of the clean level lowers chip select and starts the exchange.

The serial clock idles low (mode 0). The outgoing byte goes out most significant bit first: it is valid before the first rising edge and moves on at each falling edge. The slave changes MISO after falling edges, and the master samples it on rising edges. Because of that edge spacing, MISO enters the shift register without a synchronizer. At the end of the byte, the received value is latched into a holding register and a ready flag is raised. Downstream logic reads the value and clears the flag with a one-cycle acknowledge pulse.

Top module: `pbtn_spi_xfer`

## Requirements
- R1: During and after reset, until a press is accepted, the outputs are: `cs_n`=1, `sclk`=0, `mosi`=0, `rx_byte`=0 and `data_ready`=0.
- R2: Each rising edge of the debounced button level starts exactly one transfer. Holding the button down after that starts no further transfer.
- R3: The debouncer adopts a new button level only after the synchronized input has differed from the current level for `DEB_CYCLES` consecutive system clocks. A pulse shorter than that starts nothing.
- R4: While `cs_n` is high, `sclk` stays low. A transfer has exactly 8 rising edges of `sclk`, spaced `4*TICK_DIV` system clocks apart. The first rising edge comes `2*TICK_DIV` clocks after `cs_n` falls.
- R5: `mosi` carries `tx_byte` most significant bit first. It is valid from the cycle `cs_n` falls and changes only on falling edges of `sclk`, so it is stable while `sclk` is high.
- R6: `miso` is sampled directly on each rising edge of `sclk`. The first sampled bit becomes bit 7 of the received byte.
- R7: `cs_n` rises `2*TICK_DIV` clocks after the eighth rising edge, in the same cycle as the last falling edge of `sclk`. It has then been low for `32*TICK_DIV` clocks.
- R8: `rx_byte` changes only in the cycle `cs_n` rises, and then holds the byte received in that transfer.
- R9: `data_ready` rises only in the cycle a transfer completes. It is low in the cycle after a `rd_ack` pulse, unless a transfer completes in that same cycle. It is low when a new transfer begins.
- R10: A button press that becomes valid while a transfer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_in | input | 1 | Raw push-button level, active high, asynchronous |
| tx_byte | input | DATA_W | Byte to send, sampled when a transfer starts |
| miso | input | 1 | Serial data from the slave |
| rd_ack | input | 1 | One-cycle pulse: the consumer has taken `rx_byte` |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low slave select |
| rx_byte | output | DATA_W | Last received byte |
| data_ready | output | 1 | `rx_byte` holds a completed byte that has not yet been acknowledged |

## Verification
The properties assume that `miso` moves only after falling edges of `sclk` or while `cs_n` is high. The bench's slave model honours this by changing `miso` a short delay after each falling edge. The properties also assume that `rd_ack` is a synchronous single-cycle pulse, which the bench drives on falling clock edges. Button stimulus is deliberately hostile: bounces and short glitches are shorter than the debounce count, and presses and releases arrive during a running transfer. This stresses the start and ignore rules without breaking those assumptions.

// File: rtl/psx_pkg.sv
package psx_pkg;

   typedef enum logic {
      XF_IDLE  = 1'b0,
      XF_SHIFT = 1'b1
   } xf_state_t;

   // quarter-period positions inside one serial bit
   localparam logic [1:0] QP_RISE = 2'd1;
   localparam logic [1:0] QP_FALL = 2'd3;

endpackage

// File: rtl/psx_sync.sv
module psx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("psx_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= 1'b0;
         else        r <= d;
      end
      assign q = r;
   end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= '0;
         else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
   end

endmodule

// File: rtl/psx_debounce.sv
module psx_debounce #(
   parameter int DEB_CYCLES = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level
);

   localparam int CNT_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

   if (DEB_CYCLES < 2) begin : g_bad_deb
      $error("psx_debounce: DEB_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         level <= 1'b0;
      end else if (din == level) begin
         cnt <= '0;
      end else if (cnt == CNT_LAST) begin
         cnt   <= '0;
         level <= din;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/psx_tick.sv
module psx_tick #(
   parameter int TICK_DIV = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);

   localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

   if (TICK_DIV < 2) begin : g_bad_div
      $error("psx_tick: TICK_DIV must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   assign tick = (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr || tick) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/psx_engine.sv
module psx_engine
   import psx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              press,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              miso,
   input  logic              rd_ack,
   output logic              start,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_n,
   output logic [DATA_W-1:0] rx_byte,
   output logic              data_ready
);

   localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("psx_engine: DATA_W must be at least 2");
   end

   xf_state_t         state;
   logic [1:0]        qphase;
   logic [BIT_W-1:0]  bitn;
   logic [DATA_W-1:0] sh_tx;
   logic [DATA_W-1:0] sh_rx;

   assign start = press && (state == XF_IDLE);
   assign mosi  = sh_tx[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= XF_IDLE;
         qphase     <= '0;
         bitn       <= '0;
         sh_tx      <= '0;
         sh_rx      <= '0;
         sclk       <= 1'b0;
         cs_n       <= 1'b1;
         rx_byte    <= '0;
         data_ready <= 1'b0;
      end else begin
         if (rd_ack) data_ready <= 1'b0;
         case (state)
            XF_IDLE: begin
               if (start) begin
                  state      <= XF_SHIFT;
                  cs_n       <= 1'b0;
                  sh_tx      <= tx_byte;
                  qphase     <= '0;
                  bitn       <= '0;
                  data_ready <= 1'b0;
               end
            end
            XF_SHIFT: begin
               if (tick) begin
                  qphase <= qphase + 1'b1;
                  if (qphase == QP_RISE) begin
                     sclk  <= 1'b1;
                     sh_rx <= {sh_rx[DATA_W-2:0], miso};
                  end
                  if (qphase == QP_FALL) begin
                     sclk <= 1'b0;
                     if (bitn == BIT_LAST) begin
                        state      <= XF_IDLE;
                        cs_n       <= 1'b1;
                        sh_tx      <= '0;
                        rx_byte    <= sh_rx;
                        data_ready <= 1'b1;
                     end else begin
                        bitn  <= bitn + 1'b1;
                        sh_tx <= {sh_tx[DATA_W-2:0], 1'b0};
                     end
                  end
               end
            end
            default: state <= XF_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pbtn_spi_xfer.sv
module pbtn_spi_xfer #(
   parameter int DATA_W      = 8,
   parameter int TICK_DIV    = 125,
   parameter int DEB_CYCLES  = 500000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              btn_in,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              miso,
   input  logic              rd_ack,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_n,
   output logic [DATA_W-1:0] rx_byte,
   output logic              data_ready
);

   logic btn_sync;
   logic btn_level;
   logic btn_level_q;
   logic press;
   logic start;
   logic tick;

   psx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (btn_in),
      .q     (btn_sync)
   );

   psx_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (btn_sync),
      .level (btn_level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) btn_level_q <= 1'b0;
      else        btn_level_q <= btn_level;
   end

   assign press = btn_level && !btn_level_q;

   psx_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .tick  (tick)
   );

   psx_engine #(.DATA_W(DATA_W)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .press      (press),
      .tx_byte    (tx_byte),
      .miso       (miso),
      .rd_ack     (rd_ack),
      .start      (start),
      .sclk       (sclk),
      .mosi       (mosi),
      .cs_n       (cs_n),
      .rx_byte    (rx_byte),
      .data_ready (data_ready)
   );

endmodule

// File: rtl/psx_checker.sv
module psx_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sclk,
   input logic              mosi,
   input logic              cs_n,
   input logic              rd_ack,
   input logic [DATA_W-1:0] rx_byte,
   input logic              data_ready
);

   assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(mosi));

   assert_cs_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> $fell(sclk));

   assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(cs_n) |-> $stable(rx_byte));

   assert_ready_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ready) |-> $rose(cs_n));

   assert_ready_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack |=> (!data_ready || $rose(cs_n)));

   assert_ready_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> !data_ready);

endmodule

bind pbtn_spi_xfer psx_checker #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sclk       (sclk),
   .mosi       (mosi),
   .cs_n       (cs_n),
   .rd_ack     (rd_ack),
   .rx_byte    (rx_byte),
   .data_ready (data_ready)
);

// File: tb/pbtn_spi_xfer_bench.sv
`timescale 1ns/1ps
module pbtn_spi_xfer_bench;

   localparam int DIV = 3;
   localparam int DEB = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       btn_in = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic       miso = 1'b0;
   logic       rd_ack = 1'b0;
   logic       sclk, mosi, cs_n, data_ready;
   logic [7:0] rx_byte;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int rises = 0;
   int falls = 0;

   // {tx byte, slave byte}
   localparam logic [15:0] VEC [4] = '{16'hA53C, 16'h00FF, 16'hFF00, 16'h817E};

   pbtn_spi_xfer #(.DATA_W(8), .TICK_DIV(DIV), .DEB_CYCLES(DEB), .SYNC_STAGES(2)) u_pbtn_spi_xfer (
      .clk(clk), .rst_n(rst_n), .btn_in(btn_in), .tx_byte(tx_byte), .miso(miso),
      .rd_ack(rd_ack), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .rx_byte(rx_byte),
      .data_ready(data_ready)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc = cyc + 1;
   always @(posedge sclk) rises = rises + 1;
   always @(negedge cs_n) falls = falls + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // slave model: waits for select, returns byte seen on mosi and edge timings
   task automatic slave_xfer(input logic [7:0] sb, output logic [7:0] got,
                             output int first_r, output int last_r, output int cs_r);
      int tf;
      got = 8'h00;
      first_r = 0;
      last_r = 0;
      @(negedge cs_n);
      tf = cyc;
      miso = sb[7];
      fork
         begin
            for (int i = 0; i < 8; i++) begin
               @(posedge sclk);
               got = {got[6:0], mosi};
               if (i == 0) first_r = cyc - tf;
               last_r = cyc - tf;
            end
         end
         begin
            for (int i = 1; i < 8; i++) begin
               @(negedge sclk);
               #1 miso = sb[7-i];
            end
         end
      join
      @(posedge cs_n);
      cs_r = cyc - tf;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] got;
      int fr, lr, cr, r0, f0;

      // R1 reset state
      wait_clk(3);
      chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1 lines in reset", {cs_n, sclk, mosi}, 3'b100);
      rst_n = 1'b1;
      wait_clk(2);
      chk(rx_byte == 8'h00 && data_ready == 1'b0, "R1 result after reset", {data_ready, rx_byte}, 0);

      // R3 glitch shorter than debounce count
      btn_in = 1'b1;
      wait_clk(DEB - 3);
      btn_in = 1'b0;
      wait_clk(40);
      chk(falls == 0, "R3 short glitch starts nothing", falls, 0);

      // vector loop
      for (int v = 0; v < 4; v++) begin
         tx_byte = VEC[v][15:8];
         r0 = rises;
         f0 = falls;
         for (int b = 0; b < 3; b++) begin
            btn_in = 1'b1; wait_clk(2);
            btn_in = 1'b0; wait_clk(2);
         end
         btn_in = 1'b1;
         slave_xfer(VEC[v][7:0], got, fr, lr, cr);
         @(negedge clk);
         chk(got == VEC[v][15:8], "R5 mosi byte", got, VEC[v][15:8]);
         chk(rx_byte == VEC[v][7:0], "R6 R8 received byte", rx_byte, VEC[v][7:0]);
         chk(data_ready == 1'b1, "R9 ready after transfer", data_ready, 1);
         chk(fr == 2 * DIV, "R4 first rise delay", fr, 2 * DIV);
         chk(lr - fr == 28 * DIV, "R4 rise spacing", lr - fr, 28 * DIV);
         chk(rises - r0 == 8, "R4 rise count", rises - r0, 8);
         chk(cr == 32 * DIV, "R7 select low time", cr, 32 * DIV);
         wait_clk(60);
         chk(falls - f0 == 1, "R2 one transfer per held press", falls - f0, 1);
         btn_in = 1'b0;
         wait_clk(DEB + 10);
         chk(data_ready == 1'b1 && rx_byte == VEC[v][7:0], "R8 R9 result held", data_ready, 1);
         if (v < 3) begin
            rd_ack = 1'b1;
            @(negedge clk);
            rd_ack = 1'b0;
            chk(data_ready == 1'b0, "R9 cleared by rd_ack", data_ready, 0);
         end
      end

      // R9 new start clears ready; R10 press during busy ignored
      tx_byte = 8'h5A;
      f0 = falls;
      btn_in = 1'b1;
      fork
         slave_xfer(8'hC3, got, fr, lr, cr);
         begin
            @(negedge cs_n);
            @(negedge clk);
            chk(data_ready == 1'b0, "R9 cleared at new start", data_ready, 0);
            btn_in = 1'b0;
            wait_clk(14);
            btn_in = 1'b1;
            wait_clk(14);
         end
      join
      @(negedge clk);
      chk(got == 8'h5A && rx_byte == 8'hC3, "R5 R6 directed byte", {got, rx_byte}, 16'h5AC3);
      wait_clk(80);
      chk(falls - f0 == 1, "R10 press during transfer ignored", falls - f0, 1);
      btn_in = 1'b0;
      wait_clk(DEB + 10);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule